// File: doc/BRIEF.md
# CAN Bus Error and Arbitration-Loss Capture with Interrupt Gating

This block sits beside the bit-level engine of a CAN controller. It takes single-cycle event pulses from that engine and keeps a status word that software reads over a simple register port. Two kinds of event also carry a payload that the block latches. A bus error brings the frame position, the bit direction and the error class. An arbitration loss brings the bit index at which the node dropped out.

Each payload capture acts as a one-shot latch. The first event fills it and raises its flag. Later events of the same kind are dropped until software reads the byte that holds the capture, which re-arms it. The other event flags are sticky and clear when the byte that holds them is read.

A read/write enable word selects which flags drive the level interrupt output.

Top module: `can_err_arb_capture`

## Requirements
- R1: A bus error pulse captured while no error capture is pending raises status bit 7. It stores the frame position code in status bits 20:16, the direction in bit 21 (1 receiving, 0 transmitting) and the error class in bits 23:22 (00 bit, 01 form, 10 stuff, 11 other). Every 5-bit code is stored as given.
- R2: While the error capture is pending, further bus error pulses change neither status bits 23:16 nor bit 7.
- R3: A status read with reg_be[2] set clears status bit 7 and re-arms the error capture. The held fields stay readable. A status read without reg_be[2] leaves bit 7 set. A bus error pulse in the same cycle as a re-arming read is captured, so bit 7 stays set and it carries the new fields.
- R4: An arbitration-loss pulse captured while no arbitration capture is pending raises status bit 6 and stores the bit index in status bits 28:24. The index runs from 0 (first identifier bit) to 31 (RTR bit of an extended frame).
- R5: While the arbitration capture is pending, further pulses leave bits 28:24 unchanged. A status read with reg_be[3] set clears bit 6 and re-arms the capture. A read without reg_be[3] does not clear it.
- R6: Each simple event pulse sets its own status flag whatever the enable word holds. The positions are: receive at bit 0, transmit buffers 1, 2 and 3 at bits 1, 9 and 10, error warning at bit 2, data overrun at bit 3, wake-up at bit 4, error passive at bit 5 and ID ready at bit 8.
- R7: A simple flag clears on a status read whose byte enable covers the byte that holds it: reg_be[0] for bits 0 to 5, reg_be[1] for bits 8 to 10. A pulse in the same cycle as that read leaves the flag set.
- R8: The enable word resets to zero. A write with reg_sel=1 loads bits 10:0 from reg_wdata and ignores the byte enables. Enable bits 31:11 ignore writes and read as zero.
- R9: irq is high exactly when some status flag in bits 10:0 is set and its enable bit at the same position is set. It follows the state of the flags and the enable word in the same cycle.
- R10: Status bits 15:11 and 31:29 read as zero.
- R11: reg_rdata takes its value at the edge where reg_rd is high. It holds the word selected by reg_sel (0 status, 1 enable) as it stood before any clearing caused by that read, and it keeps that value until the next read.
- R12: After reset the status word, the enable word, reg_rdata and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_err_pulse | input | 1 | Bus error event |
| bus_err_pos | input | 5 | Frame position code of the error |
| bus_err_rx | input | 1 | Direction of the errored bit, 1 receiving |
| bus_err_type | input | 2 | Error class |
| arb_lost_pulse | input | 1 | Arbitration loss event |
| arb_lost_bit | input | 5 | Bit index of the arbitration loss |
| evt_rx | input | 1 | Frame received |
| evt_tx | input | 3 | Transmit buffer done, one bit per buffer |
| evt_warn | input | 1 | Error warning change |
| evt_overrun | input | 1 | Data overrun |
| evt_wake | input | 1 | Wake-up |
| evt_passive | input | 1 | Error passive change |
| evt_idrdy | input | 1 | ID ready |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_rd | input | 1 | Read strobe |
| reg_be | input | 4 | Read byte enables |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |

## Verification
An event pulse takes effect at the edge that samples it. Its flag, its captured fields and irq are valid one clock after the pulse is driven. A read returns data one clock after the strobe, with the pre-clear contents, and the clearing it causes shows up on the read after that. An enable write changes irq in the following cycle. The bench drives every input just after a rising edge and samples just after the next one, so each check lands on the first cycle its result is due. Coincident read-and-event cases are checked across two reads so that the pre-clear and post-edge values are told apart.

// File: rtl/can_cap_pkg.sv
package can_cap_pkg;
   localparam int EN_W    = 11;
   localparam int ERR_LSB = 16;
   localparam int ARB_LSB = 24;

   localparam int F_RX   = 0;
   localparam int F_TX1  = 1;
   localparam int F_WARN = 2;
   localparam int F_OVR  = 3;
   localparam int F_WAKE = 4;
   localparam int F_PASS = 5;
   localparam int F_ARB  = 6;
   localparam int F_BERR = 7;
   localparam int F_IDR  = 8;
   localparam int F_TX2  = 9;
   localparam int F_TX3  = 10;

   // flags owned by the sticky bank (all but the two capture flags)
   localparam logic [EN_W-1:0] SIMPLE_MASK = 11'b111_0011_1111;

   typedef enum logic [0:0] {
      REG_STATUS = 1'b0,
      REG_ENABLE = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/can_cap_latch.sv
module can_cap_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   input  logic [W-1:0] fields,
   input  logic         rearm,
   output logic         pending,
   output logic [W-1:0] held
);
   if (W < 1) begin : g_bad_w
      $error("can_cap_latch: W must be at least 1");
   end

   logic take;
   assign take = evt && (!pending || rearm);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         held    <= '0;
      end else if (take) begin
         pending <= 1'b1;
         held    <= fields;
      end else if (rearm) begin
         pending <= 1'b0;
      end
   end

   // R2 / R5: a pending capture is frozen until re-armed
   a_r2_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !rearm |=> $stable(held) && pending);

   // R1 / R4: a free latch takes the event payload
   a_r1_capture_free: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !pending |=> pending && (held == $past(fields)));

   // R3 / R5: re-arm without new event drops the flag
   a_r3_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rearm && !evt |=> !pending);
endmodule

// File: rtl/can_cap_flags.sv
module can_cap_flags #(
   parameter int           N    = 11,
   parameter logic [N-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_n
      $error("can_cap_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      if (MASK[i]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (set[i]) q <= 1'b1;
            else if (clr[i]) q <= 1'b0;
         end
         assign flags[i] = q;

         // R6: a pulse always leaves its flag set
         a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
         // R7: a clearing read without a pulse empties the flag
         a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !set[i] |=> !flags[i]);
      end else begin : g_tied
         logic unused_bit;
         assign unused_bit = set[i] ^ clr[i];
         assign flags[i]   = 1'b0;
      end
   end
endmodule

// File: rtl/can_cap_enable.sv
module can_cap_enable #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en <= '0;
      else if (wr) en <= wdata;
   end

   // R8: a write is visible the next cycle
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> en == $past(wdata));
   // R8: no write, no change
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(en));
endmodule

// File: rtl/can_err_arb_capture.sv
module can_err_arb_capture
   import can_cap_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int POS_W   = 5,
   parameter int ETYPE_W = 2,
   parameter int ARB_W   = 5,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_err_pulse,
   input  logic [POS_W-1:0]   bus_err_pos,
   input  logic               bus_err_rx,
   input  logic [ETYPE_W-1:0] bus_err_type,
   input  logic               arb_lost_pulse,
   input  logic [ARB_W-1:0]   arb_lost_bit,
   input  logic               evt_rx,
   input  logic [2:0]         evt_tx,
   input  logic               evt_warn,
   input  logic               evt_overrun,
   input  logic               evt_wake,
   input  logic               evt_passive,
   input  logic               evt_idrdy,
   input  logic               reg_sel,
   input  logic               reg_rd,
   input  logic [REG_W/8-1:0] reg_be,
   input  logic               reg_wr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic               irq
);
   localparam int ERRF_W   = POS_W + 1 + ETYPE_W;
   localparam int ERR_BYTE = ERR_LSB / 8;
   localparam int ARB_BYTE = ARB_LSB / 8;

   if (ERR_LSB + ERRF_W > ARB_LSB) begin : g_bad_err
      $error("error capture fields overlap the arbitration field");
   end
   if (ARB_LSB + ARB_W > REG_W) begin : g_bad_arb
      $error("arbitration field does not fit the register width");
   end
   if (REG_W < 32 || (REG_W % 8) != 0) begin : g_bad_reg
      $error("REG_W must be a multiple of 8 and at least 32");
   end

   logic status_rd;
   logic en_wr;
   assign status_rd = reg_rd && (reg_sel == REG_STATUS);
   assign en_wr     = reg_wr && (reg_sel == REG_ENABLE);

   // bus error capture
   logic              err_pend;
   logic [ERRF_W-1:0] err_held;
   can_cap_latch #(.W(ERRF_W)) u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (bus_err_pulse),
      .fields  ({bus_err_type, bus_err_rx, bus_err_pos}),
      .rearm   (status_rd && reg_be[ERR_BYTE]),
      .pending (err_pend),
      .held    (err_held)
   );

   // arbitration loss capture
   logic             arb_pend;
   logic [ARB_W-1:0] arb_held;
   can_cap_latch #(.W(ARB_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (arb_lost_pulse),
      .fields  (arb_lost_bit),
      .rearm   (status_rd && reg_be[ARB_BYTE]),
      .pending (arb_pend),
      .held    (arb_held)
   );

   // sticky event flags
   logic [EN_W-1:0] ev_set;
   logic [EN_W-1:0] ev_clr;
   logic [EN_W-1:0] sticky;

   always_comb begin
      ev_set         = '0;
      ev_set[F_RX]   = evt_rx;
      ev_set[F_TX1]  = evt_tx[0];
      ev_set[F_TX2]  = evt_tx[1];
      ev_set[F_TX3]  = evt_tx[2];
      ev_set[F_WARN] = evt_warn;
      ev_set[F_OVR]  = evt_overrun;
      ev_set[F_WAKE] = evt_wake;
      ev_set[F_PASS] = evt_passive;
      ev_set[F_IDR]  = evt_idrdy;
   end

   for (genvar i = 0; i < EN_W; i++) begin : g_clr
      assign ev_clr[i] = status_rd && reg_be[i/8];
   end

   can_cap_flags #(.N(EN_W), .MASK(SIMPLE_MASK)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_set),
      .clr   (ev_clr),
      .flags (sticky)
   );

   // enable word
   logic [EN_W-1:0] en_q;
   logic            unused_wdata;
   assign unused_wdata = ^reg_wdata[REG_W-1:EN_W];

   can_cap_enable #(.W(EN_W)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (en_wr),
      .wdata (reg_wdata[EN_W-1:0]),
      .en    (en_q)
   );

   // status word assembly
   logic [EN_W-1:0]  flag_vec;
   logic [REG_W-1:0] status_w;
   logic [REG_W-1:0] enable_w;

   always_comb begin
      flag_vec         = sticky;
      flag_vec[F_ARB]  = arb_pend;
      flag_vec[F_BERR] = err_pend;
      status_w                        = '0;
      status_w[EN_W-1:0]              = flag_vec;
      status_w[ERR_LSB +: ERRF_W]     = err_held;
      status_w[ARB_LSB +: ARB_W]      = arb_held;
      enable_w                        = '0;
      enable_w[EN_W-1:0]              = en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= (reg_sel == REG_ENABLE) ? enable_w : status_w;
   end

   // interrupt: combinational or one extra register stage
   logic irq_now;
   assign irq_now = |(flag_vec & en_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_now;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_now;
   end

   // R11: status read returns the pre-read error flag
   a_r11_rdata_preclear: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd |=> reg_rdata[F_BERR] == $past(err_pend));
   // R11: read data is held between reads
   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
   // R9: nothing enabled means no interrupt
   a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) && !IRQ_REG |-> !irq);
endmodule

// File: tb/can_err_arb_capture_test.sv
`timescale 1ns/1ps
module can_err_arb_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_err_pulse = 0;
   logic [4:0]  bus_err_pos = 0;
   logic        bus_err_rx = 0;
   logic [1:0]  bus_err_type = 0;
   logic        arb_lost_pulse = 0;
   logic [4:0]  arb_lost_bit = 0;
   logic        evt_rx = 0;
   logic [2:0]  evt_tx = 0;
   logic        evt_warn = 0, evt_overrun = 0, evt_wake = 0, evt_passive = 0, evt_idrdy = 0;
   logic        reg_sel = 0, reg_rd = 0, reg_wr = 0;
   logic [3:0]  reg_be = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   can_err_arb_capture uut (
      .clk(clk), .rst_n(rst_n),
      .bus_err_pulse(bus_err_pulse), .bus_err_pos(bus_err_pos),
      .bus_err_rx(bus_err_rx), .bus_err_type(bus_err_type),
      .arb_lost_pulse(arb_lost_pulse), .arb_lost_bit(arb_lost_bit),
      .evt_rx(evt_rx), .evt_tx(evt_tx), .evt_warn(evt_warn),
      .evt_overrun(evt_overrun), .evt_wake(evt_wake), .evt_passive(evt_passive),
      .evt_idrdy(evt_idrdy),
      .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_be(reg_be), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic sel, input logic [3:0] be, output logic [31:0] d);
      reg_sel = sel; reg_be = be; reg_rd = 1'b1;
      tick();
      reg_rd = 1'b0; reg_be = 4'h0;
      d = reg_rdata;
   endtask

   task automatic wr_en(input logic [31:0] v);
      reg_sel = 1'b1; reg_wdata = v; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic set_evt(input int i, input logic v);
      case (i)
         0:  evt_rx      = v;
         1:  evt_tx[0]   = v;
         2:  evt_warn    = v;
         3:  evt_overrun = v;
         4:  evt_wake    = v;
         5:  evt_passive = v;
         8:  evt_idrdy   = v;
         9:  evt_tx[1]   = v;
         10: evt_tx[2]   = v;
         default: ;
      endcase
   endtask

   task automatic pulse_err(input logic [4:0] p, input logic dir, input logic [1:0] t);
      bus_err_pos = p; bus_err_rx = dir; bus_err_type = t; bus_err_pulse = 1'b1;
      tick();
      bus_err_pulse = 1'b0;
   endtask

   task automatic pulse_arb(input logic [4:0] b);
      arb_lost_bit = b; arb_lost_pulse = 1'b1;
      tick();
      arb_lost_pulse = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  efld;
      int simple [9] = '{0, 1, 2, 3, 4, 5, 8, 9, 10};

      repeat (3) tick();
      // R12: reset state
      check("R12 rdata", reg_rdata, 32'h0);
      check("R12 irq", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      tick();
      rd(1'b0, 4'h0, d); check("R12 status", d, 32'h0);
      rd(1'b1, 4'h0, d); check("R12 enable", d, 32'h0);

      // R8: enable width and reserved bits
      wr_en(32'hFFFF_FFFF);
      rd(1'b1, 4'h0, d); check("R8 enable all ones", d, 32'h0000_07FF);
      wr_en(32'h0000_0555);
      rd(1'b1, 4'hF, d); check("R8 enable pattern", d, 32'h0000_0555);
      wr_en(32'h0);
      rd(1'b1, 4'h0, d); check("R8 enable cleared", d, 32'h0);

      // R6 / R7 / R9: each simple flag
      foreach (simple[k]) begin
         int i = simple[k];
         set_evt(i, 1'b1); tick(); set_evt(i, 1'b0);
         check("R9 no irq when disabled", {31'h0, irq}, 32'h0);
         rd(1'b0, 4'h0, d); check("R6 flag set regardless of enable", d, 32'h1 << i);
         wr_en(32'h1 << i);
         check("R9 irq when enabled", {31'h0, irq}, 32'h1);
         wr_en(~(32'h1 << i));
         check("R9 other enables give no irq", {31'h0, irq}, 32'h0);
         rd(1'b0, (i < 8) ? 4'b0010 : 4'b0001, d);
         check("R7 wrong byte read keeps flag", d, 32'h1 << i);
         rd(1'b0, (i < 8) ? 4'b0001 : 4'b0010, d);
         check("R11 read shows pre-clear flag", d, 32'h1 << i);
         rd(1'b0, 4'h0, d); check("R7 flag cleared by its byte", d, 32'h0);
         wr_en(32'h0);
      end

      // R7: pulse coincident with a clearing read
      evt_rx = 1'b1;
      rd(1'b0, 4'b0001, d);
      evt_rx = 1'b0;
      check("R7 coincident read shows old value", d, 32'h0);
      rd(1'b0, 4'b0001, d); check("R7 coincident pulse kept flag", d, 32'h1);
      rd(1'b0, 4'h0, d); check("R7 flag cleared afterwards", d, 32'h0);

      // R1 / R2 / R3: sweep every error payload
      wr_en(32'h80);
      for (int c = 0; c < 256; c++) begin
         logic [4:0] p = c[4:0];
         logic       dr = c[5];
         logic [1:0] t = c[7:6];
         efld = {t, dr, p};
         pulse_err(p, dr, t);
         check("R9 irq on bus error", {31'h0, irq}, 32'h1);
         pulse_err(~p, ~dr, ~t);
         rd(1'b0, 4'b1011, d);
         check("R2 fields frozen, R3 no re-arm", d, {8'h00, efld, 16'h0080});
         rd(1'b0, 4'b0100, d);
         check("R1 capture fields", d, {8'h00, efld, 16'h0080});
         rd(1'b0, 4'h0, d);
         check("R3 flag cleared, fields kept", d, {8'h00, efld, 16'h0000});
         check("R9 irq dropped after re-arm", {31'h0, irq}, 32'h0);
      end

      // R3: error coincident with the re-arming read
      pulse_err(5'b00011, 1'b0, 2'b01);
      bus_err_pos = 5'b11010; bus_err_rx = 1'b1; bus_err_type = 2'b10; bus_err_pulse = 1'b1;
      rd(1'b0, 4'b0100, d);
      bus_err_pulse = 1'b0;
      check("R3 coincident read shows first capture", d, {8'h00, 8'b01_0_00011, 16'h0080});
      rd(1'b0, 4'b0100, d);
      check("R3 coincident error captured", d, {8'h00, 8'b10_1_11010, 16'h0080});
      rd(1'b0, 4'h0, d);

      // R4 / R5: sweep every arbitration index
      wr_en(32'h40);
      for (int b = 0; b < 32; b++) begin
         logic [4:0] bb = b[4:0];
         pulse_arb(bb);
         check("R9 irq on arbitration loss", {31'h0, irq}, 32'h1);
         pulse_arb(~bb);
         rd(1'b0, 4'b0111, d);
         check("R5 frozen, no re-arm", {d[31:24], d[7:0]}, {3'b000, bb, 8'h40});
         rd(1'b0, 4'b1000, d);
         check("R4 capture bit index", {d[31:24], d[7:0]}, {3'b000, bb, 8'h40});
         rd(1'b0, 4'h0, d);
         check("R5 flag cleared", {d[31:24], d[7:0]}, {3'b000, bb, 8'h00});
      end

      // R10: everything set, reserved bits still zero
      evt_rx = 1; evt_tx = 3'b111; evt_warn = 1; evt_overrun = 1;
      evt_wake = 1; evt_passive = 1; evt_idrdy = 1;
      bus_err_pos = 5'h1F; bus_err_rx = 1; bus_err_type = 2'b11; bus_err_pulse = 1;
      arb_lost_bit = 5'h1F; arb_lost_pulse = 1;
      tick();
      evt_rx = 0; evt_tx = 0; evt_warn = 0; evt_overrun = 0;
      evt_wake = 0; evt_passive = 0; evt_idrdy = 0;
      bus_err_pulse = 0; arb_lost_pulse = 0;
      rd(1'b0, 4'h0, d);
      check("R10 reserved bits zero", d, 32'h1FFF_07FF);
      // R11: rdata holds between reads while state changes
      rd(1'b1, 4'h0, d);
      wr_en(32'h7FF);
      check("R11 rdata held", reg_rdata, 32'h0000_0040);
      check("R9 irq all enabled", {31'h0, irq}, 32'h1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule